// File: doc/BRIEF.md
# Bus Master Address Phase Launcher

This block lets an embedded processor core open a master transaction on a 32-bit multiplexed address/data bus of the PCI kind. The core writes one 24-bit launch word. That word holds the byte-lane enables, the bus command and the low half of the target address. The upper half of the address comes from a separate control register and enters the block as a plain input. A ready flag interlocks the launch word. The flag must be set for a write to be taken, and a write taken in master mode clears it. The flag is set again when the transaction ends.

Once a launch is pending, the block waits until the first data phase can actually complete. For a write command, the outbound FIFO must hold data. For a read command, the inbound FIFO must have room. Only then does it raise the bus request. After the grant it drives the full address and the command for a single address-phase cycle. It then drives the byte enables on the command/byte-enable lines through the data phases, until a done pulse closes the transaction. Data movement itself, parity, retry and abort handling are not part of this block.

Top module: `bma_launcher`

## Requirements
- R1: After a synchronous reset, the launch word reads back as zero and the ready flag `addr_rdy` is 1. `bus_req`, `ad_oe` and `cbe_oe` are all 0.
- R2: A launch write (`lw_we`) is stored only while `addr_rdy` is 1. A write made while the flag is 0 leaves the read-back word `lw_q` unchanged.
- R3: When a write is taken with `master_en` at 1, `addr_rdy` reads 0 in the next cycle. When a write is taken with `master_en` at 0, the word is stored, the flag stays 1 and no request is raised.
- R4: The launch word layout is: bits 23:20 are the byte enables (bit 23 = lane 3, bit 20 = lane 0), bits 19:16 are the command, and bits 15:0 are address bits 15:0. An odd command is a write and needs `ob_empty` at 0 before a request. An even command is a read and needs `ib_full` at 0.
- R5: `bus_req` rises in the cycle after the FIFO condition is first seen in the pending state. It then stays high until a grant is sampled, even if the FIFO condition goes away. A grant while `bus_req` is 0 has no effect.
- R6: In the cycle after a grant is sampled with `bus_req` high, `ad_out` carries {`hi_addr`, bits 15:0}, `cbe_out` carries the command, both enables are 1 and `bus_req` is 0. This lasts exactly one cycle.
- R7: In every cycle after the address phase until the transaction ends, `cbe_out` carries the byte-enable field, `cbe_oe` is 1 and `ad_oe` is 0.
- R8: A `xfer_done` pulse during the data phases ends the transaction: in the next cycle `addr_rdy` is 1 and `cbe_oe` is 0. A `xfer_done` at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Master mode enabled |
| hi_addr | input | 16 | Address bits 31:16 from the control register |
| lw_we | input | 1 | Core write strobe for the launch word |
| lw_wdata | input | 24 | Launch word write data |
| lw_q | output | 24 | Launch word read-back |
| addr_rdy | output | 1 | Ready flag; launch writes are accepted while 1 |
| ob_empty | input | 1 | Outbound data FIFO empty |
| ib_full | input | 1 | Inbound data FIFO full |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus ownership grant |
| xfer_done | input | 1 | One-cycle end-of-transaction pulse |
| ad_out | output | 32 | Address/data lines, address-phase value |
| ad_oe | output | 1 | Drive enable for the address/data lines |
| cbe_out | output | 4 | Command / byte-enable lines |
| cbe_oe | output | 1 | Drive enable for command / byte-enable lines |

## Verification
Two events can land in the same cycle: the end of a transaction, which sets the ready flag, and a core write to the launch word. The bench raises `lw_we` in the same cycle as the `xfer_done` pulse. It then checks that the read-back word is unchanged, because the flag was still clear at that edge. A second write one cycle later must be accepted. A similar collision occurs when the FIFO condition drops in the cycle the request is pending. The bench checks that the request stays high and that the grant still produces a correct address phase.

// File: rtl/bma_pkg.sv
package bma_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_ADDR = 2'd2,
    SQ_DATA = 2'd3
  } sq_state_t;
endpackage

// File: rtl/bma_launch_reg.sv
module bma_launch_reg #(
  parameter int LO_W  = 16,
  parameter int CBE_W = 4,
  localparam int LW_W = 2 * CBE_W + LO_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            master_en,
  input  logic            we,
  input  logic [LW_W-1:0] wdata,
  input  logic            txn_end,
  output logic [LW_W-1:0] q,
  output logic            rdy,
  output logic            launch
);
  logic accept;
  assign accept = we && rdy;
  assign launch = accept && master_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      rdy <= 1'b1;
    end else begin
      if (accept) q <= wdata;
      if (txn_end)     rdy <= 1'b1;
      else if (launch) rdy <= 1'b0;
    end
  end

  AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (we && !rdy) |=> $stable(q)); // R2
  AST_RDY_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (we && rdy && master_en) |=> !rdy); // R3
  AST_NO_EN_KEEPS_RDY: assert property (@(posedge clk) disable iff (rst)
    (we && rdy && !master_en && !txn_end) |=> rdy); // R3
endmodule

// File: rtl/bma_req_gate.sv
module bma_req_gate (
  input  logic is_write,
  input  logic ob_empty,
  input  logic ib_full,
  output logic can_go
);
  always_comb begin
    if (is_write) can_go = !ob_empty;
    else          can_go = !ib_full;
  end
endmodule

// File: rtl/bma_bus_seq.sv
module bma_bus_seq
  import bma_pkg::*;
#(
  parameter int HI_W  = 16,
  parameter int LO_W  = 16,
  parameter int CBE_W = 4,
  localparam int AD_W = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic             can_go,
  input  logic [HI_W-1:0]  hi_addr,
  input  logic [LO_W-1:0]  lo_addr,
  input  logic [CBE_W-1:0] cmd,
  input  logic [CBE_W-1:0] be,
  input  logic             bus_gnt,
  input  logic             xfer_done,
  output logic             bus_req,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic [CBE_W-1:0] cbe_out,
  output logic             cbe_oe,
  output logic             txn_end
);
  sq_state_t state;

  assign txn_end = (state == SQ_DATA) && xfer_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      bus_req <= 1'b0;
      ad_out  <= '0;
      ad_oe   <= 1'b0;
      cbe_out <= '0;
      cbe_oe  <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (launch) state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (bus_req && bus_gnt) begin
            state   <= SQ_ADDR;
            bus_req <= 1'b0;
            ad_out  <= {hi_addr, lo_addr};
            ad_oe   <= 1'b1;
            cbe_out <= cmd;
            cbe_oe  <= 1'b1;
          end else begin
            bus_req <= bus_req | can_go;
          end
        end
        SQ_ADDR: begin
          state   <= SQ_DATA;
          ad_oe   <= 1'b0;
          cbe_out <= be;
        end
        default: begin
          if (xfer_done) begin
            state   <= SQ_IDLE;
            cbe_oe  <= 1'b0;
            cbe_out <= '0;
          end
        end
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt) |=> bus_req); // R5
  AST_GNT_TO_ADDR: assert property (@(posedge clk) disable iff (rst)
    (bus_req && bus_gnt) |=> (ad_oe && cbe_oe && !bus_req)); // R6
  AST_ADDR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    ad_oe |=> (!ad_oe && cbe_oe)); // R6
  AST_AD_NEEDS_CBE: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> cbe_oe); // R7
  AST_NO_REQ_WHILE_DRIVING: assert property (@(posedge clk) disable iff (rst)
    cbe_oe |-> !bus_req); // R5
endmodule

// File: rtl/bma_launcher.sv
module bma_launcher #(
  parameter int HI_W  = 16,
  parameter int LO_W  = 16,
  parameter int CBE_W = 4,
  localparam int LW_W = 2 * CBE_W + LO_W,
  localparam int AD_W = HI_W + LO_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             master_en,
  input  logic [HI_W-1:0]  hi_addr,
  input  logic             lw_we,
  input  logic [LW_W-1:0]  lw_wdata,
  output logic [LW_W-1:0]  lw_q,
  output logic             addr_rdy,
  input  logic             ob_empty,
  input  logic             ib_full,
  output logic             bus_req,
  input  logic             bus_gnt,
  input  logic             xfer_done,
  output logic [AD_W-1:0]  ad_out,
  output logic             ad_oe,
  output logic [CBE_W-1:0] cbe_out,
  output logic             cbe_oe
);
  localparam int CMD_LO = LO_W;
  localparam int BE_LO  = LO_W + CBE_W;

  logic             launch, can_go, txn_end;
  logic [CBE_W-1:0] cmd_f, be_f;
  logic [LO_W-1:0]  lo_f;

  assign lo_f  = lw_q[LO_W-1:0];
  assign cmd_f = lw_q[CMD_LO +: CBE_W];
  assign be_f  = lw_q[BE_LO +: CBE_W];

  bma_launch_reg #(.LO_W(LO_W), .CBE_W(CBE_W)) u_lreg (
    .clk(clk), .rst(rst), .master_en(master_en), .we(lw_we),
    .wdata(lw_wdata), .txn_end(txn_end), .q(lw_q), .rdy(addr_rdy),
    .launch(launch)
  );

  bma_req_gate u_gate (
    .is_write(cmd_f[0]), .ob_empty(ob_empty), .ib_full(ib_full),
    .can_go(can_go)
  );

  bma_bus_seq #(.HI_W(HI_W), .LO_W(LO_W), .CBE_W(CBE_W)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .can_go(can_go),
    .hi_addr(hi_addr), .lo_addr(lo_f), .cmd(cmd_f), .be(be_f),
    .bus_gnt(bus_gnt), .xfer_done(xfer_done), .bus_req(bus_req),
    .ad_out(ad_out), .ad_oe(ad_oe), .cbe_out(cbe_out), .cbe_oe(cbe_oe),
    .txn_end(txn_end)
  );

  AST_RDY_LOW_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (bus_req || ad_oe) |-> !addr_rdy); // R3
  AST_END_SETS_RDY: assert property (@(posedge clk) disable iff (rst)
    (cbe_oe && !ad_oe && xfer_done) |=> (addr_rdy && !cbe_oe)); // R8
endmodule

// File: tb/bma_launcher_test.sv
module bma_launcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_en = 1'b1;
  logic [15:0] hi_addr = '0;
  logic        lw_we = 1'b0;
  logic [23:0] lw_wdata = '0;
  logic [23:0] lw_q;
  logic        addr_rdy;
  logic        ob_empty = 1'b0;
  logic        ib_full = 1'b0;
  logic        bus_req;
  logic        bus_gnt = 1'b0;
  logic        xfer_done = 1'b0;
  logic [31:0] ad_out;
  logic        ad_oe;
  logic [3:0]  cbe_out;
  logic        cbe_oe;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  bma_launcher uut (
    .clk(clk), .rst(rst), .master_en(master_en), .hi_addr(hi_addr),
    .lw_we(lw_we), .lw_wdata(lw_wdata), .lw_q(lw_q), .addr_rdy(addr_rdy),
    .ob_empty(ob_empty), .ib_full(ib_full), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .xfer_done(xfer_done), .ad_out(ad_out),
    .ad_oe(ad_oe), .cbe_out(cbe_out), .cbe_oe(cbe_oe)
  );

  // {launch word, hi_addr}
  localparam logic [39:0] VEC [4] = '{
    {24'h5_3_1234, 16'hABCD},
    {24'hF_6_0000, 16'h0001},
    {24'h1_7_FFFF, 16'hFFFF},
    {24'hA_2_8001, 16'h7E00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [23:0] d);
    lw_we = 1'b1; lw_wdata = d;
    tick(1);
    lw_we = 1'b0;
  endtask

  // full transaction; requests granted as soon as seen
  task automatic run_txn(input logic [23:0] d, input logic [15:0] hi);
    hi_addr = hi;
    wr(d);
    chk("R3 rdy cleared", {31'd0, addr_rdy}, 32'd0);
    chk("R5 no req yet", {31'd0, bus_req}, 32'd0);
    tick(1);
    chk("R5 req raised", {31'd0, bus_req}, 32'd1);
    bus_gnt = 1'b1;
    tick(1);
    bus_gnt = 1'b0;
    chk("R6 address", ad_out, {hi, d[15:0]});
    chk("R6 command", {28'd0, cbe_out}, {28'd0, d[19:16]});
    chk("R6 enables/req", {29'd0, ad_oe, cbe_oe, bus_req}, 32'd6);
    tick(1);
    chk("R7 byte enables", {28'd0, cbe_out}, {28'd0, d[23:20]});
    chk("R7 enables", {30'd0, ad_oe, cbe_oe}, 32'd1);
    tick(1);
    chk("R7 held", {27'd0, cbe_out, cbe_oe}, {27'd0, d[23:20], 1'b1});
    xfer_done = 1'b1;
    tick(1);
    xfer_done = 1'b0;
    chk("R8 end", {30'd0, addr_rdy, cbe_oe}, 32'd2);
  endtask

  initial begin
    fork
      begin
        tick(3);
        rst = 1'b0;
        tick(1);
        chk("R1 lw_q", {8'd0, lw_q}, 32'd0);
        chk("R1 flags", {28'd0, addr_rdy, bus_req, ad_oe, cbe_oe}, 32'd8);

        for (int k = 0; k < 4; k++) run_txn(VEC[k][39:16], VEC[k][15:0]);

        // R4: write command waits for outbound data
        ob_empty = 1'b1; ib_full = 1'b0;
        hi_addr = 16'h1111;
        wr(24'h3_B_0042);
        tick(3);
        chk("R4 write gated", {31'd0, bus_req}, 32'd0);
        bus_gnt = 1'b1;  // R5: grant without request ignored
        tick(1);
        bus_gnt = 1'b0;
        chk("R5 stray grant", {30'd0, ad_oe, cbe_oe}, 32'd0);
        // R2: write while busy ignored
        wr(24'hEEEEEE);
        chk("R2 ignored", {8'd0, lw_q}, 32'h003B0042);
        ob_empty = 1'b0;
        tick(1);
        ob_empty = 1'b1;  // R5: condition drops, request holds
        tick(1);
        chk("R5 req", {31'd0, bus_req}, 32'd1);
        tick(2);
        chk("R5 req held", {31'd0, bus_req}, 32'd1);
        bus_gnt = 1'b1;
        tick(1);
        bus_gnt = 1'b0;
        chk("R6 addr after hold", ad_out, 32'h11110042);
        tick(1);
        // same cycle: end pulse and a core write
        xfer_done = 1'b1; lw_we = 1'b1; lw_wdata = 24'h123456;
        tick(1);
        xfer_done = 1'b0; lw_we = 1'b0;
        chk("R2 write at end ignored", {8'd0, lw_q}, 32'h003B0042);
        chk("R8 rdy set", {31'd0, addr_rdy}, 32'd1);
        xfer_done = 1'b1;  // R8: stray done in idle
        tick(1);
        xfer_done = 1'b0;
        chk("R8 stray done", {30'd0, addr_rdy, cbe_oe}, 32'd2);

        // R4: read command waits for inbound room
        ib_full = 1'b1; ob_empty = 1'b1;
        wr(24'hF_0_0100);
        chk("R2 accepted", {8'd0, lw_q}, 32'h00F00100);
        tick(3);
        chk("R4 read gated", {31'd0, bus_req}, 32'd0);
        ib_full = 1'b0;
        tick(2);
        chk("R4 read go", {31'd0, bus_req}, 32'd1);
        bus_gnt = 1'b1;
        tick(2);
        bus_gnt = 1'b0;
        xfer_done = 1'b1;
        tick(1);
        xfer_done = 1'b0;
        ob_empty = 1'b0;

        // R3: master mode off
        master_en = 1'b0;
        wr(24'h1_1_0002);
        chk("R3 stored", {8'd0, lw_q}, 32'h00110002);
        tick(3);
        chk("R3 no launch", {30'd0, addr_rdy, bus_req}, 32'd2);
        master_en = 1'b1;
      end
      begin
        tick(5000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule